// File: doc/BRIEF.md
# Boot-Aware Address Region Decoder

This block sits between a 32-bit processor address bus and the targets behind it. It turns an address into at most one select: on-chip SRAM, the external bus interface, or the on-chip peripherals. For every aligned access it also produces four little-endian byte-lane enables. The 4 MB at the top of the space belongs to the peripherals, and the 4 MB at the bottom belongs to internal memory. All addresses between the two go to the external bus.

At reset the processor fetches its vectors from address zero, so zero first maps onto the nonvolatile boot device on external chip select 0. During this phase the 256 KB SRAM is reachable at an alternate base inside the low region. Software can copy vectors there and then issue a one-way remap command. From that point the SRAM sits at address zero.

While reset is low, the block records the level of a shared boot-mode pin. When reset is released it fixes the boot data width from that record, and the external bus interface uses this width. After reset the pin becomes free for general I/O use, and the width it chose stays fixed.

Top module: `addr_region_decoder`

## Requirements
- R1: When `req_i` is high and the access is aligned, an address whose bits [31:22] are all ones asserts only `sel_periph_o`. An address whose bits [31:22] are neither all zeros nor all ones asserts only `sel_ext_o`, with `ext_boot_o` low.
- R2: While `remapped_o` is low, an aligned access in 0x0000_0000..0x0003_FFFF asserts `sel_ext_o` with `ext_boot_o` high (boot device on chip select 0). `sel_sram_o` stays low for such an access.
- R3: While `remapped_o` is low, an aligned access in 0x0030_0000..0x0033_FFFF asserts only `sel_sram_o`, and `sram_index_o` equals address bits [17:2].
- R4: While `remapped_o` is high, an aligned access in 0x0000_0000..0x0003_FFFF asserts only `sel_sram_o` with `sram_index_o` = address bits [17:2]. In this state the window at 0x0030_0000 raises `dec_err_o` and asserts no select.
- R5: Any other aligned address with bits [31:22] all zero raises `dec_err_o` and asserts no select, in both remap states.
- R6: A high `remap_cmd_i` at a rising clock edge sets `remapped_o` from that edge on. `remapped_o` is low after reset and only reset clears it. Further commands have no effect.
- R7: If `boot_pin_i` held one value v at all of the last 10 rising edges before reset release, then from the first rising edge with `rst_n` high `boot_is8_o` equals v (1 = 8-bit, 0 = 16-bit boot device) and `boot_unstable_o` is 0. Reset must be held for at least 10 cycles.
- R8: If those 10 samples disagree, `boot_is8_o` takes the most recent of them and `boot_unstable_o` is 1.
- R9: After that first edge, `boot_is8_o` and `boot_unstable_o` keep their values until the next reset, whatever `boot_pin_i` does.
- R10: `size_i` codes 0 = byte, 1 = half-word, 2 = word. Bit i of `lane_en_o` enables byte i, little-endian. A byte access enables lane `addr_i[1:0]`. A half-word enables lanes 1:0 or 3:2 according to `addr_i[1]`. A word enables all four. Lanes are driven only when a select is asserted.
- R11: A half-word with `addr_i[0]` = 1, a word with `addr_i[1:0]` ≠ 0, or `size_i` = 3 raises `align_err_o`. Such an access asserts no select, no lane and no `dec_err_o`.
- R12: With `req_i` low, every select, lane and error output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, released in step with clk |
| boot_pin_i | input | 1 | Shared boot-mode pin, 1 = 8-bit boot device |
| remap_cmd_i | input | 1 | One-cycle remap command |
| req_i | input | 1 | Access valid |
| addr_i | input | 32 | Byte address |
| size_i | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| sel_sram_o | output | 1 | On-chip SRAM select |
| sel_ext_o | output | 1 | External bus interface select |
| ext_boot_o | output | 1 | External access goes to boot device on chip select 0 |
| sel_periph_o | output | 1 | Peripheral region select |
| sram_index_o | output | 16 | SRAM word index, valid with sel_sram_o |
| lane_en_o | output | 4 | Byte-lane enables, bit i = byte i |
| align_err_o | output | 1 | Misaligned access or illegal size |
| dec_err_o | output | 1 | Unmapped address in internal-memory region |
| remapped_o | output | 1 | Remap has been applied |
| boot_is8_o | output | 1 | Captured boot width, 1 = 8-bit |
| boot_unstable_o | output | 1 | Boot pin samples disagreed |

## Verification
Boot-width capture is the hardest behaviour to reach, because the pin only matters in a short window that closes when reset is released. The bench holds reset for 14 cycles and drives a chosen level into each of them. The first four levels are deliberately the opposite of the final window, so a history that is too long or shifted would be exposed. It runs separate reset sequences with uniform ones, uniform zeros, a single late flip and a single early flip. After each release it toggles the pin while it checks the latched width. Between resets it sends biased random addresses around every region boundary, in both remap states.

// File: rtl/ard_pkg.sv
package ard_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    TGT_NONE   = 2'd0,
    TGT_SRAM   = 2'd1,
    TGT_EXT    = 2'd2,
    TGT_PERIPH = 2'd3
  } target_e;

endpackage

// File: rtl/ard_boot_capture.sv
module ard_boot_capture #(
  parameter int NSAMP = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic is8_o,
  output logic unstable_o
);

  logic [NSAMP-1:0] hist_q;
  logic [NSAMP-1:0] hist_d;
  logic             done_q;
  logic             done_d;
  logic             is8_q;
  logic             is8_d;
  logic             unst_q;
  logic             unst_d;
  logic             agree;

  // history shifts only until the capture has been taken
  always_comb begin
    hist_d = hist_q;
    if (!done_q) begin
      hist_d = {hist_q[NSAMP-2:0], pin_i};
    end
  end

  always_ff @(posedge clk) begin
    hist_q <= hist_d;
  end

  assign agree = (&hist_q) | ~(|hist_q);

  always_comb begin
    done_d = done_q;
    is8_d  = is8_q;
    unst_d = unst_q;
    if (!done_q) begin
      done_d = 1'b1;
      is8_d  = hist_q[0];
      unst_d = ~agree;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      is8_q  <= 1'b0;
      unst_q <= 1'b0;
    end else begin
      done_q <= done_d;
      is8_q  <= is8_d;
      unst_q <= unst_d;
    end
  end

  assign is8_o      = is8_q;
  assign unstable_o = unst_q;

endmodule

// File: rtl/ard_remap_flag.sv
module ard_remap_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_i,
  output logic flag_o
);

  logic flag_q;
  logic flag_d;

  always_comb begin
    flag_d = flag_q | cmd_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (cmd_i) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/ard_region_map.sv
module ard_region_map
  import ard_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          REGION_SH = 22,
  parameter int          SRAM_AW   = 18,
  parameter logic [31:0] ALT_BASE  = 32'h0030_0000
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               remapped_i,
  output target_e            tgt_o,
  output logic               boot_o,
  output logic               dec_err_o,
  output logic [SRAM_AW-3:0] index_o
);

  localparam int HI_W  = ADDR_W - REGION_SH;
  localparam int WIN_W = ADDR_W - SRAM_AW;
  localparam logic [WIN_W-1:0] ALT_TAG = ALT_BASE[ADDR_W-1:SRAM_AW];

  logic in_low;
  logic in_top;
  logic in_zero;
  logic in_alt;

  assign in_low  = (addr_i[ADDR_W-1:REGION_SH] == {HI_W{1'b0}});
  assign in_top  = (addr_i[ADDR_W-1:REGION_SH] == {HI_W{1'b1}});
  assign in_zero = (addr_i[ADDR_W-1:SRAM_AW] == {WIN_W{1'b0}});
  assign in_alt  = (addr_i[ADDR_W-1:SRAM_AW] == ALT_TAG);

  always_comb begin
    tgt_o     = TGT_NONE;
    boot_o    = 1'b0;
    dec_err_o = 1'b0;
    if (in_top) begin
      tgt_o = TGT_PERIPH;
    end else if (!in_low) begin
      tgt_o = TGT_EXT;
    end else if (in_zero) begin
      if (remapped_i) begin
        tgt_o = TGT_SRAM;
      end else begin
        tgt_o  = TGT_EXT;
        boot_o = 1'b1;
      end
    end else if (in_alt && !remapped_i) begin
      tgt_o = TGT_SRAM;
    end else begin
      dec_err_o = 1'b1;
    end
  end

  assign index_o = addr_i[SRAM_AW-1:2];

endmodule

// File: rtl/ard_lane_gen.sv
module ard_lane_gen
  import ard_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [1:0]       size_i,
  input  logic [1:0]       low_i,
  output logic [LANES-1:0] lanes_o,
  output logic             misalign_o
);

  always_comb begin
    lanes_o    = '0;
    misalign_o = 1'b0;
    unique case (acc_size_e'(size_i))
      SZ_BYTE: lanes_o[low_i] = 1'b1;
      SZ_HALF: begin
        misalign_o = low_i[0];
        lanes_o    = low_i[1] ? LANES'(4'b1100) : LANES'(4'b0011);
      end
      SZ_WORD: begin
        misalign_o = |low_i;
        lanes_o    = '1;
      end
      default: misalign_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/addr_region_decoder.sv
module addr_region_decoder
  import ard_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          REGION_SH = 22,
  parameter int          SRAM_AW   = 18,
  parameter logic [31:0] ALT_BASE  = 32'h0030_0000,
  parameter int          NSAMP     = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               boot_pin_i,
  input  logic               remap_cmd_i,
  input  logic               req_i,
  input  logic [31:0]        addr_i,
  input  logic [1:0]         size_i,
  output logic               sel_sram_o,
  output logic               sel_ext_o,
  output logic               ext_boot_o,
  output logic               sel_periph_o,
  output logic [15:0]        sram_index_o,
  output logic [3:0]         lane_en_o,
  output logic               align_err_o,
  output logic               dec_err_o,
  output logic               remapped_o,
  output logic               boot_is8_o,
  output logic               boot_unstable_o
);

  localparam int IDX_W = SRAM_AW - 2;

  target_e          tgt;
  logic             boot_win;
  logic             map_err;
  logic [IDX_W-1:0] idx;
  logic [3:0]       lanes;
  logic             misalign;
  logic             remap_q;
  logic             go;

  ard_remap_flag u_remap (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd_i  (remap_cmd_i),
    .flag_o (remap_q)
  );

  ard_boot_capture #(.NSAMP(NSAMP)) u_boot (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (boot_pin_i),
    .is8_o      (boot_is8_o),
    .unstable_o (boot_unstable_o)
  );

  ard_region_map #(
    .ADDR_W    (ADDR_W),
    .REGION_SH (REGION_SH),
    .SRAM_AW   (SRAM_AW),
    .ALT_BASE  (ALT_BASE)
  ) u_map (
    .addr_i     (addr_i[ADDR_W-1:0]),
    .remapped_i (remap_q),
    .tgt_o      (tgt),
    .boot_o     (boot_win),
    .dec_err_o  (map_err),
    .index_o    (idx)
  );

  ard_lane_gen #(.LANES(4)) u_lanes (
    .size_i     (size_i),
    .low_i      (addr_i[1:0]),
    .lanes_o    (lanes),
    .misalign_o (misalign)
  );

  assign go = req_i & ~misalign;

  always_comb begin
    sel_sram_o   = go & (tgt == TGT_SRAM);
    sel_ext_o    = go & (tgt == TGT_EXT);
    sel_periph_o = go & (tgt == TGT_PERIPH);
    ext_boot_o   = go & (tgt == TGT_EXT) & boot_win;
    dec_err_o    = go & map_err;
    align_err_o  = req_i & misalign;
    lane_en_o    = (go && tgt != TGT_NONE) ? lanes : 4'b0000;
    sram_index_o = 16'(idx);
  end

  assign remapped_o = remap_q;

endmodule

// File: rtl/ard_checker.sv
module ard_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        remap_cmd_i,
  input logic        req_i,
  input logic [31:0] addr_i,
  input logic        sel_sram_o,
  input logic        sel_ext_o,
  input logic        ext_boot_o,
  input logic        sel_periph_o,
  input logic [3:0]  lane_en_o,
  input logic        align_err_o,
  input logic        dec_err_o,
  input logic        remapped_o,
  input logic        boot_is8_o,
  input logic        boot_unstable_o
);

  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= 2'd0;
    end else if (age_q != 2'd3) begin
      age_q <= age_q + 2'd1;
    end
  end

  p_one_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_sram_o, sel_ext_o, sel_periph_o}));

  p_top_is_periph_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !align_err_o && (&addr_i[31:22])) |-> sel_periph_o);

  p_boot_needs_ext_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ext_boot_o |-> (sel_ext_o && !remapped_o));

  p_remap_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    remap_cmd_i |=> remapped_o);

  p_remap_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    remapped_o |=> remapped_o);

  p_width_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> ($stable(boot_is8_o) && $stable(boot_unstable_o)));

  p_misalign_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    align_err_o |-> (!sel_sram_o && !sel_ext_o && !sel_periph_o &&
                     lane_en_o == 4'b0000 && !dec_err_o));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |-> (!sel_sram_o && !sel_ext_o && !sel_periph_o &&
                lane_en_o == 4'b0000 && !align_err_o && !dec_err_o));

  p_deccerr_nosel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err_o |-> (!sel_sram_o && !sel_ext_o && !sel_periph_o));

endmodule

bind addr_region_decoder ard_checker u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .remap_cmd_i     (remap_cmd_i),
  .req_i           (req_i),
  .addr_i          (addr_i),
  .sel_sram_o      (sel_sram_o),
  .sel_ext_o       (sel_ext_o),
  .ext_boot_o      (ext_boot_o),
  .sel_periph_o    (sel_periph_o),
  .lane_en_o       (lane_en_o),
  .align_err_o     (align_err_o),
  .dec_err_o       (dec_err_o),
  .remapped_o      (remapped_o),
  .boot_is8_o      (boot_is8_o),
  .boot_unstable_o (boot_unstable_o)
);

// File: tb/addr_region_decoder_bench.sv
module addr_region_decoder_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        boot_pin_i;
  logic        remap_cmd_i;
  logic        req_i;
  logic [31:0] addr_i;
  logic [1:0]  size_i;
  logic        sel_sram_o;
  logic        sel_ext_o;
  logic        ext_boot_o;
  logic        sel_periph_o;
  logic [15:0] sram_index_o;
  logic [3:0]  lane_en_o;
  logic        align_err_o;
  logic        dec_err_o;
  logic        remapped_o;
  logic        boot_is8_o;
  logic        boot_unstable_o;

  int checks;
  int fails;
  int cycles;
  bit done;

  addr_region_decoder u_addr_region_decoder (
    .clk             (clk),
    .rst_n           (rst_n),
    .boot_pin_i      (boot_pin_i),
    .remap_cmd_i     (remap_cmd_i),
    .req_i           (req_i),
    .addr_i          (addr_i),
    .size_i          (size_i),
    .sel_sram_o      (sel_sram_o),
    .sel_ext_o       (sel_ext_o),
    .ext_boot_o      (ext_boot_o),
    .sel_periph_o    (sel_periph_o),
    .sram_index_o    (sram_index_o),
    .lane_en_o       (lane_en_o),
    .align_err_o     (align_err_o),
    .dec_err_o       (dec_err_o),
    .remapped_o      (remapped_o),
    .boot_is8_o      (boot_is8_o),
    .boot_unstable_o (boot_unstable_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (addr %h size %0d remap %0b)",
               req, act, exp, addr_i, size_i, remapped_o);
    end
  endtask

  // expected {sram, ext, boot, periph, lanes[3:0], align, dec}
  function automatic logic [9:0] model(input logic req, input logic [31:0] a,
                                       input logic [1:0] sz, input logic rm);
    logic s, e, b, p, al, de;
    logic [3:0] ln;
    s = 0; e = 0; b = 0; p = 0; al = 0; de = 0; ln = 4'h0;
    if (req) begin
      if (sz == 2'd3 || (sz == 2'd1 && a[0]) || (sz == 2'd2 && a[1:0] != 2'b00)) begin
        al = 1;
      end else begin
        if (a >= 32'hFFC0_0000) p = 1;
        else if (a >= 32'h0040_0000) e = 1;
        else if (a < 32'h0004_0000) begin
          if (rm) s = 1; else begin e = 1; b = 1; end
        end else if (!rm && a >= 32'h0030_0000 && a < 32'h0034_0000) s = 1;
        else de = 1;
        if (!de) begin
          case (sz)
            2'd0: ln = 4'b0001 << a[1:0];
            2'd1: ln = a[1] ? 4'b1100 : 4'b0011;
            default: ln = 4'b1111;
          endcase
        end
      end
    end
    return {s, e, b, p, ln, al, de};
  endfunction

  function automatic string tag_for(input logic [31:0] a, input logic [1:0] sz, input logic rq);
    if (!rq) return "R12";
    if (sz == 2'd3 || (sz == 2'd1 && a[0]) || (sz == 2'd2 && a[1:0] != 0)) return "R11";
    if (a >= 32'h0040_0000) return "R1";
    if (a < 32'h0004_0000) return remapped_o ? "R4" : "R2";
    if (a >= 32'h0030_0000 && a < 32'h0034_0000) return remapped_o ? "R4" : "R3";
    return "R5";
  endfunction

  task automatic access(input logic rq, input logic [31:0] a, input logic [1:0] sz);
    logic [9:0] exp;
    logic [9:0] act;
    string t;
    @(negedge clk);
    req_i = rq; addr_i = a; size_i = sz;
    #1;
    exp = model(rq, a, sz, remapped_o);
    act = {sel_sram_o, sel_ext_o, ext_boot_o, sel_periph_o, lane_en_o, align_err_o, dec_err_o};
    t = tag_for(a, sz, rq);
    check(t, 32'(act), 32'(exp));
    if (exp[9]) check("R3/R4 index", 32'(sram_index_o), 32'(a[17:2]));
    if (exp[5:2] != 0 && rq) check("R10 lanes", 32'(lane_en_o), 32'(exp[5:2]));
  endtask

  function automatic logic [31:0] pick_addr(input int k);
    logic [31:0] r;
    r = $urandom;
    case (k % 6)
      0: return {10'h3FF, r[21:0]};
      1: return {10'h000, 4'h0, r[17:0]};
      2: return 32'h0030_0000 | {14'h0, r[17:0]};
      3: return {10'h000, r[21:0]};
      4: return 32'h0040_0000 + (r % 32'hFF80_0000);
      default: return r;
    endcase
  endfunction

  task automatic boot_reset(input logic [13:0] levels);
    // levels[13] is driven first, levels[0] last before release
    @(negedge clk);
    rst_n = 1'b0; req_i = 0; remap_cmd_i = 0;
    for (int i = 13; i >= 0; i--) begin
      boot_pin_i = levels[i];
      @(negedge clk);
    end
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic boot_check(input logic [13:0] levels, input logic e8, input logic eu);
    boot_reset(levels);
    check("R7/R8 width", 32'(boot_is8_o), 32'(e8));
    check("R7/R8 unstable", 32'(boot_unstable_o), 32'(eu));
    for (int i = 0; i < 4; i++) begin
      boot_pin_i = ~boot_pin_i;
      @(negedge clk);
    end
    check("R9 width held", 32'(boot_is8_o), 32'(e8));
    check("R9 unstable held", 32'(boot_unstable_o), 32'(eu));
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; boot_pin_i = 0; remap_cmd_i = 0; req_i = 0; addr_i = 0; size_i = 0;
    checks = 0; fails = 0; done = 0;

    // boot width cases: four decoy levels then the 10-sample window
    boot_check(14'b0000_1111111111, 1'b1, 1'b0);   // R7 all ones
    check("R6 reset state", 32'(remapped_o), 32'd0);
    boot_check(14'b1111_0000000000, 1'b0, 1'b0);   // R7 all zeros
    boot_check(14'b0000_1111111110, 1'b0, 1'b1);   // R8 late flip
    boot_check(14'b1111_0111111111, 1'b1, 1'b1);   // R8 early flip

    // directed corners before remap
    access(1, 32'h0000_0000, 2'd2);
    access(1, 32'h0003_FFFC, 2'd2);
    access(1, 32'h0004_0000, 2'd2);
    access(1, 32'h002F_FFFC, 2'd2);
    access(1, 32'h0030_0000, 2'd0);
    access(1, 32'h0033_FFFE, 2'd1);
    access(1, 32'h0034_0000, 2'd2);
    access(1, 32'h003F_FFFF, 2'd0);
    access(1, 32'h0040_0000, 2'd0);
    access(1, 32'hFFBF_FFFC, 2'd2);
    access(1, 32'hFFC0_0000, 2'd1);
    access(1, 32'hFFFF_FFFD, 2'd0);
    access(1, 32'h0040_0003, 2'd1);
    access(1, 32'h0040_0002, 2'd2);
    access(1, 32'h0030_0000, 2'd3);
    access(0, 32'h0030_0000, 2'd2);
    for (int k = 0; k < 600; k++) access($urandom_range(0, 7) != 0, pick_addr(k), 2'($urandom));

    // remap command
    check("R6 before remap", 32'(remapped_o), 32'd0);
    @(negedge clk); remap_cmd_i = 1;
    @(negedge clk); remap_cmd_i = 0;
    check("R6 set", 32'(remapped_o), 32'd1);
    @(negedge clk); remap_cmd_i = 1;
    @(negedge clk); remap_cmd_i = 0;
    repeat (3) @(negedge clk);
    check("R6 sticky", 32'(remapped_o), 32'd1);

    access(1, 32'h0000_0000, 2'd2);
    access(1, 32'h0003_FFFF, 2'd0);
    access(1, 32'h0004_0000, 2'd0);
    access(1, 32'h0030_0000, 2'd2);
    access(1, 32'hFFC0_0002, 2'd1);
    for (int k = 0; k < 600; k++) access($urandom_range(0, 7) != 0, pick_addr(k), 2'($urandom));

    // reset clears remap
    boot_check(14'b0101_1111111111, 1'b1, 1'b0);
    check("R6 cleared by reset", 32'(remapped_o), 32'd0);
    access(1, 32'h0000_0010, 2'd2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule